// File: doc/BRIEF.md
# Symmetric Bit-Serial Distributed-Arithmetic FIR Filter

This block filters a stream of two's-complement samples with a fixed, even-symmetric impulse response of ten taps. It does this without multipliers. Each accepted sample enters a tapped delay line. Every tap value is then copied into a shift register and sent out one bit per clock, least significant bit first, after one bit of sign extension. Two taps that share a coefficient are combined by a one-bit serial adder. The five resulting sum bits of each clock select one word of a 32-entry table. Each word holds the sum of the coefficients whose pair bit is set.

A scaling accumulator adds each table word at the binary weight of its bit slot. It loads the first slot's word instead of adding it. On the final, sign-bearing slot it subtracts the word by inverting it and adding one. After eleven slots the full-precision result appears on the output with a one-cycle strobe.

The coefficients are a flat parameter vector, and the table contents are computed from that vector during elaboration. A new sample can be accepted every eleven clocks.

Top module: `symfir_da`

## Requirements
- R1: A synchronous reset drives out_valid low and out_data to zero, and it empties the delay line. After reset, an impulse produces only the coefficient sequence, with no trace of samples sent before the reset.
- R2: in_valid is accepted when the filter is idle, or on the final slot of a computation in progress. The result for an accepted sample appears exactly DW+1 (11) clocks after the accepting edge, with out_valid high for one clock. Every accepted sample yields exactly one result.
- R3: in_valid that arrives while a computation is in any slot other than its final one is ignored. Neither the delay line nor any later result is affected by it.
- R4: The result for the newest sample x[n] is the sum over p = 0..4 of h[p]·(x[n−p] + x[n−9+p]). It is delivered as a 24-bit signed value with no rounding or truncation.
- R5: Pair sums are formed over 11 bit slots from sign-extended operands. The extreme sums 2·511 and 2·(−512) are therefore exact.
- R6: The 32-entry coefficient table is derived from the parameter COEF, which holds h[0] in bits [CW−1:0] and h[p] in bits [(p+1)·CW−1:p·CW]. An isolated unit impulse therefore yields h0, h1, h2, h3, h4, h4, h3, h2, h1, h0 on ten consecutive results.
- R7: The slot that carries the sign bit is subtracted as a two's-complement value. Negative pair sums therefore give correctly signed results.
- R8: out_data holds its value between strobes.
- R9: Samples sent every 11 clocks with no idle gap are all accepted and all filtered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offers a new sample |
| in_data | input | DW (10) | Two's-complement sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | OW (24) | Signed full-precision filter result |

## Verification
The bound checker observes several properties on every clock:

- the strobe never lasts longer than a single cycle;
- each strobe comes exactly eleven clocks after the accepting edge;
- the delay line does not move when an offer is made in the middle of a computation;
- the output does not move between strobes;
- the output is quiet after reset.

The arithmetic itself can only be shown by the bench's scenarios, which compare each result against a direct convolution. These scenarios are:

- the impulse response;
- saturated positive and negative runs;
- pseudo-random data with varied gaps;
- negative-heavy data;
- offers made mid-computation;
- back-to-back timing;
- a reset in the middle of a stream.

// File: rtl/symfir_pkg.sv
package symfir_pkg;
   localparam int unsigned COEF_MAX_BITS = 512;

   // signed coefficient of pair idx taken from a flat vector, cw bits each
   function automatic int pair_coef(input logic [COEF_MAX_BITS-1:0] flat,
                                    input int cw, input int idx);
      int v;
      v = 0;
      for (int b = 0; b < 32; b++)
         v[b] = (b < cw) ? flat[idx*cw + b] : flat[idx*cw + cw - 1];
      return v;
   endfunction

   // table word for one address: sum of coefficients whose address bit is set
   function automatic int table_word(input logic [COEF_MAX_BITS-1:0] flat,
                                     input int npair, input int cw, input int addr);
      int acc;
      acc = 0;
      for (int p = 0; p < npair; p++)
         if (addr[p]) acc += pair_coef(flat, cw, p);
      return acc;
   endfunction
endpackage

// File: rtl/symfir_ctrl.sv
module symfir_ctrl #(
   parameter int SW  = 11,
   localparam int SLW = (SW > 1) ? $clog2(SW) : 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   output logic           load,
   output logic           busy,
   output logic           first,
   output logic           last,
   output logic [SLW-1:0] slot
);
   assign last  = busy && (slot == SLW'(SW - 1));
   assign first = busy && (slot == '0);
   assign load  = in_valid && (!busy || last);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         slot <= '0;
      end else if (load) begin
         busy <= 1'b1;
         slot <= '0;
      end else if (last) begin
         busy <= 1'b0;
      end else if (busy) begin
         slot <= slot + 1'b1;
      end
   end
endmodule

// File: rtl/symfir_serial_front.sv
module symfir_serial_front #(
   parameter int NTAPS = 10,
   parameter int DW    = 10,
   localparam int NPAIR = NTAPS / 2,
   localparam int SW    = DW + 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load,
   input  logic                   step,
   input  logic [DW-1:0]          in_data,
   output logic [NPAIR-1:0]       sum_bits,
   output logic [NTAPS*DW-1:0]    taps_flat
);
   logic [DW-1:0] dly   [NTAPS];
   logic [SW-1:0] shreg [NTAPS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NTAPS; k++) begin
            dly[k]   <= '0;
            shreg[k] <= '0;
         end
      end else if (load) begin
         dly[0]   <= in_data;
         shreg[0] <= {in_data[DW-1], in_data};
         for (int k = 1; k < NTAPS; k++) begin
            dly[k]   <= dly[k-1];
            shreg[k] <= {dly[k-1][DW-1], dly[k-1]};
         end
      end else if (step) begin
         for (int k = 0; k < NTAPS; k++)
            shreg[k] <= shreg[k] >> 1;
      end
   end

   for (genvar k = 0; k < NTAPS; k++) begin : g_flat
      assign taps_flat[k*DW +: DW] = dly[k];
   end

   // one serial adder per coefficient-sharing pair
   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic a_bit, b_bit, cy, cy_next;
      assign a_bit       = shreg[p][0];
      assign b_bit       = shreg[NTAPS-1-p][0];
      assign sum_bits[p] = a_bit ^ b_bit ^ cy;
      assign cy_next     = (a_bit & b_bit) | (cy & (a_bit ^ b_bit));
      always_ff @(posedge clk) begin
         if (rst || load) cy <= 1'b0;
         else if (step)   cy <= cy_next;
      end
   end
endmodule

// File: rtl/symfir_coef_rom.sv
module symfir_coef_rom
   import symfir_pkg::*;
#(
   parameter int NPAIR = 5,
   parameter int CW    = 10,
   parameter int LW    = 13,
   parameter logic [NPAIR*CW-1:0] COEF = '0,
   localparam int DEPTH = 1 << NPAIR
) (
   input  logic [NPAIR-1:0]       addr,
   output logic signed [LW-1:0]   word
);
   localparam logic [COEF_MAX_BITS-1:0] FLAT = COEF_MAX_BITS'(COEF);

   if (NPAIR * CW > COEF_MAX_BITS) begin : g_bad_coef
      $error("coefficient vector wider than the package limit");
   end

   logic signed [LW-1:0] rom [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_rom
      localparam int VAL = table_word(FLAT, NPAIR, CW, a);
      assign rom[a] = LW'(VAL);
   end

   assign word = rom[addr];
endmodule

// File: rtl/symfir_scale_acc.sv
module symfir_scale_acc #(
   parameter int LW  = 13,
   parameter int OW  = 24,
   parameter int SW  = 11,
   localparam int SLW = (SW > 1) ? $clog2(SW) : 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  step,
   input  logic                  first,
   input  logic                  last,
   input  logic [SLW-1:0]        slot,
   input  logic signed [LW-1:0]  word,
   output logic                  out_valid,
   output logic signed [OW-1:0]  out_data
);
   logic signed [OW-1:0] acc, ext, weighted, term, total;

   always_comb begin
      ext      = {{(OW-LW){word[LW-1]}}, word};
      weighted = ext << slot;
      term     = last ? (~weighted + OW'(1)) : weighted;
      total    = first ? term : acc + term;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc       <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= step && last;
         if (step) acc <= total;
         if (step && last) out_data <= total;
      end
   end
endmodule

// File: rtl/symfir_da.sv
module symfir_da #(
   parameter int NTAPS = 10,
   parameter int DW    = 10,
   parameter int CW    = 10,
   parameter logic [(NTAPS/2)*CW-1:0] COEF =
      {10'h137, 10'h096, 10'h3C3, 10'h017, 10'h3F7},
   localparam int NPAIR = NTAPS / 2,
   localparam int SW    = DW + 1,
   localparam int LW    = CW + ((NPAIR > 1) ? $clog2(NPAIR) : 1),
   localparam int OW    = SW + LW,
   localparam int SLW   = (SW > 1) ? $clog2(SW) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [DW-1:0]        in_data,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_data
);
   if (NTAPS < 2 || (NTAPS % 2) != 0) begin : g_bad_taps
      $error("NTAPS must be even and at least 2");
   end
   if (DW < 2 || CW < 2) begin : g_bad_width
      $error("DW and CW must be at least 2");
   end

   logic                 acc_load, eng_busy, slot_first, slot_last;
   logic [SLW-1:0]       slot;
   logic [NPAIR-1:0]     addr;
   logic signed [LW-1:0] word;
   logic [NTAPS*DW-1:0]  taps_flat;

   symfir_ctrl #(.SW(SW)) u_ctrl (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .load(acc_load), .busy(eng_busy), .first(slot_first),
      .last(slot_last), .slot(slot)
   );

   symfir_serial_front #(.NTAPS(NTAPS), .DW(DW)) u_front (
      .clk(clk), .rst(rst), .load(acc_load), .step(eng_busy),
      .in_data(in_data), .sum_bits(addr), .taps_flat(taps_flat)
   );

   symfir_coef_rom #(.NPAIR(NPAIR), .CW(CW), .LW(LW), .COEF(COEF)) u_rom (
      .addr(addr), .word(word)
   );

   symfir_scale_acc #(.LW(LW), .OW(OW), .SW(SW)) u_acc (
      .clk(clk), .rst(rst), .step(eng_busy), .first(slot_first),
      .last(slot_last), .slot(slot), .word(word),
      .out_valid(out_valid), .out_data(out_data)
   );
endmodule

// File: rtl/symfir_da_chk.sv
module symfir_da_chk #(
   parameter int SW = 11,
   parameter int TW = 100,
   parameter int OW = 24
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          out_valid,
   input logic [OW-1:0] out_data,
   input logic          load,
   input logic          last,
   input logic          busy,
   input logic [TW-1:0] taps
);
   int  lat_cnt;
   logic rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)                  lat_cnt <= 0;
      else if (load)            lat_cnt <= 1;
      else if (lat_cnt != 0 && lat_cnt <= SW) lat_cnt <= lat_cnt + 1;
   end

   // R1: outputs quiet on the cycle after a reset edge
   always_ff @(posedge clk) begin
      if (rst_q) begin
         assert_reset_quiet_R1: assert (!out_valid && out_data == '0)
            else $error("output not cleared by reset");
      end
   end

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($past(lat_cnt) == SW));

   assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && busy && !last) |=> $stable(taps));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));
endmodule

bind symfir_da symfir_da_chk #(.SW(SW), .TW(NTAPS*DW), .OW(OW)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
   .out_data(out_data), .load(acc_load), .last(slot_last),
   .busy(eng_busy), .taps(taps_flat)
);

// File: tb/symfir_da_bench.sv
module symfir_da_bench;
   localparam int NT = 10, DW = 10, CW = 10, NP = 5, OW = 24, LAT = 11;
   localparam logic [NP*CW-1:0] COEF = {10'h137, 10'h096, 10'h3C3, 10'h017, 10'h3F7};
   int h [NP] = '{-9, 23, -61, 150, 311};

   logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic out_valid;
   logic signed [OW-1:0] out_data;

   symfir_da #(.NTAPS(NT), .DW(DW), .CW(CW), .COEF(COEF)) u_symfir_da (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int hist [NT];
   longint exp_q[$];
   int cyc_q[$];
   string tag_q[$];
   int checks = 0, fails = 0;
   logic [15:0] lf = 16'hACE1;

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ref_next(int s);
      longint y;
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = s;
      y = 0;
      for (int p = 0; p < NP; p++) y += longint'(h[p]) * (hist[p] + hist[NT-1-p]);
      return y;
   endfunction

   // driver: called at a negedge, pushes expected item
   task automatic send(int s, int gap, string tag);
      in_valid = 1'b1;
      in_data  = DW'(s);
      @(negedge clk);
      in_valid = 1'b0;
      exp_q.push_back(ref_next(s));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
      repeat (gap - 1) @(negedge clk);
   endtask

   // R3: an offer in slot 3 of the running computation must be dropped
   task automatic send_intrude(int s, int junk);
      in_valid = 1'b1;
      in_data  = DW'(s);
      @(negedge clk);
      in_valid = 1'b0;
      exp_q.push_back(ref_next(s));
      cyc_q.push_back(cyc);
      tag_q.push_back("R3 offer during computation ignored");
      repeat (3) @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(junk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   function automatic int lfsr_sample();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      return int'($signed(lf[9:0]));
   endfunction

   // monitor: scoreboard pop and compare
   bit hold_pending = 1'b0;
   longint hold_val;
   always @(negedge clk) begin
      if (!rst) begin
         if (hold_pending) begin
            check("R8 output held after strobe", longint'(out_data), hold_val);
            hold_pending = 1'b0;
         end
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R2 strobe without accepted sample", 1, 0);
            end else begin
               longint e;
               int c0;
               string t;
               e  = exp_q.pop_front();
               c0 = cyc_q.pop_front();
               t  = tag_q.pop_front();
               check(t, longint'(out_data), e);
               check("R2 latency", cyc - c0, LAT);
               hold_val     = longint'(out_data);
               hold_pending = !out_valid ? 1'b0 : 1'b1;
            end
         end
      end
   end

   bit done = 1'b0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NT; k++) hist[k] = 0;
      repeat (3) @(negedge clk);
      check("R1 reset out_valid", out_valid, 0);
      check("R1 reset out_data", longint'(out_data), 0);
      rst = 1'b0;
      @(negedge clk);

      // R6 impulse response reproduces symmetric coefficients
      send(1, 11, "R6 impulse response");
      for (int i = 0; i < NT - 1; i++) send(0, 11, "R6 impulse response");

      // R5 extreme pair sums, back-to-back (R9)
      for (int i = 0; i < NT; i++) send(511, 11, "R5 R9 max positive run");
      for (int i = 0; i < NT; i++) send(-512, 11, "R5 R9 max negative run");
      for (int i = 0; i < 4; i++) begin
         send(511, 11, "R5 alternating extremes");
         send(-512, 11, "R5 alternating extremes");
      end

      // R4 pseudo-random data with varied idle gaps
      for (int i = 0; i < 30; i++)
         send(lfsr_sample(), (i % 3 == 0) ? 14 : 11, "R4 random convolution");

      // R7 negative-heavy data
      for (int i = 0; i < 12; i++)
         send(-1 - 41 * i, 12, "R7 negative samples");

      // R3 offers during computation
      for (int i = 0; i < 5; i++) send_intrude(37 * i - 80, 511 - i);
      for (int i = 0; i < NT; i++) send(0, 11, "R3 history excludes dropped offers");

      // R1 reset mid-stream clears history and in-flight work
      send(200, 4, "R1 dropped by reset");
      rst = 1'b1;
      repeat (2) @(negedge clk);
      exp_q.delete();
      cyc_q.delete();
      tag_q.delete();
      for (int k = 0; k < NT; k++) hist[k] = 0;
      check("R1 mid-stream reset out_valid", out_valid, 0);
      check("R1 mid-stream reset out_data", longint'(out_data), 0);
      rst = 1'b0;
      @(negedge clk);
      send(1, 11, "R1 clean impulse after reset");
      for (int i = 0; i < NT - 1; i++) send(0, 11, "R1 clean impulse after reset");

      repeat (20) @(negedge clk);
      check("R2 every accepted sample produced a result", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule